// File: doc/BRIEF.md
# Issue Group Former with Fused-Entry Splitting

This block sits after an in-order micro-operation queue. Each clock it takes entries from the queue head and packs them into one issue group of up to four micro-operations. A queue entry is either a single operation or a fused operation that turns into two micro-operations only when it issues. A fused entry therefore uses one queue slot but two group lanes. Both of its halves must go out in the same group. When a group has only one lane left and the next entry is fused, the group closes early with a hole, and the fused entry leads the next group. Entries never pass one another.

Entries arrive through a valid/ready enqueue port. One transfer carries up to four entries and a count. The port is ready only while the internal queue has room for a full batch of four, and a batch is taken on a clock edge where valid and ready are both high. The issue side is a four-lane valid/ready port. A group that is offered stays unchanged until the consumer takes it. While the group waits, no queue entry is used up. Two counters report the number of issuing cycles and the number of micro-operations issued, so throughput can be measured directly.

Top module: `issue_grouper`

## Requirements
- R1: A stream of single entries issues four micro-operations on every clock once the queue is primed.
- R2: A fused entry fills two adjacent lanes with the same tag. The first half has half flag 0 in the lower lane and the second half has half flag 1 in the next lane up. A single entry fills one lane with half flag 0.
- R3: Both halves of a fused entry issue in the same group. If fewer than two lanes are left, the group closes with its upper lanes empty and the fused entry waits for the next group.
- R4: Micro-operations leave in queue order. An entry that does not fit ends the group, and no later entry is placed ahead of it.
- R5: Valid lanes are packed from lane 0 upward, so the lane-valid mask of an offered group is 1, 3, 7 or 15.
- R6: While out_valid is high and out_ready is low, the lane signals and the counters hold their values and no queue entry is consumed.
- R7: A repeating stream of fused then single entries sustains three micro-operations per clock. A stream of only fused entries sustains four per clock.
- R8: perf_cycles increases by one, and perf_uops by the number of valid lanes, on each cycle where out_valid and out_ready are both high. Both counters hold otherwise.
- R9: After reset, out_valid is low, both counters are zero and in_ready is high.
- R10: in_ready is high only when at least four queue slots are free. Entries offered while it is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Enqueue batch valid |
| in_ready | output | 1 | Queue has room for a full batch |
| in_count | input | 3 | Number of entries in the batch, 1 to 4 |
| in_split | input | 4 | Per-entry fused flag, entry k on bit k |
| in_tag | input | 32 | Per-entry tag, entry k on bits 8k+7:8k |
| out_valid | output | 1 | Issue group offered |
| out_ready | input | 1 | Consumer takes the group |
| out_lane_vld | output | 4 | Per-lane valid |
| out_lane_half | output | 4 | Per-lane half flag, 1 marks the second half of a fused entry |
| out_lane_tag | output | 32 | Per-lane tag, lane k on bits 8k+7:8k |
| perf_cycles | output | 32 | Count of issuing cycles |
| perf_uops | output | 32 | Count of issued micro-operations |

## Verification
The assertions assume that in_count lies between 1 and four whenever in_valid is high. Under that assumption the queue can never overflow and a pop can never exceed the queue occupancy. The stimulus meets this by always offering full batches of four entries and by taking in_ready as the only sign of acceptance. The assertions also assume nothing about out_ready, which the bench holds low for several cycles and drives freely elsewhere.

// File: rtl/issue_pkg.sv
`timescale 1ns/1ps
package issue_pkg;
  parameter int unsigned TAG_W = 8;

  // queue entry: fused flag plus tag
  typedef struct packed {
    logic             split;
    logic [TAG_W-1:0] tag;
  } q_entry_t;

  // one issue lane
  typedef struct packed {
    logic             vld;
    logic             half;
    logic [TAG_W-1:0] tag;
  } lane_t;
endpackage

// File: rtl/uop_fifo.sv
`timescale 1ns/1ps
module uop_fifo
  import issue_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(WIDTH+1)-1:0]   push_n,
  input  q_entry_t                     push_ent [WIDTH],
  input  logic [$clog2(WIDTH+1)-1:0]   pop_n,
  output q_entry_t                     head [WIDTH],
  output logic [WIDTH-1:0]             head_vld,
  output logic                         space_ok
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  q_entry_t      mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_q + PW'(pop_n);
      wr_q  <= wr_q + PW'(push_n);
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WIDTH; k++) begin
      if ($clog2(WIDTH+1)'(k) < push_n) mem_q[wr_q + PW'(k)] <= push_ent[k];
    end
  end

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      head[k]     = mem_q[rd_q + PW'(k)];
      head_vld[k] = (CW'(k) < cnt_q);
    end
  end

  assign space_ok = (cnt_q <= CW'(DEPTH - WIDTH));

  // the queue never holds more than its depth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != '0) |-> ((cnt_q + CW'(push_n)) <= CW'(DEPTH)));

  // pops only take entries that are present, in order from the head
  assert_pop_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= cnt_q);
endmodule

// File: rtl/group_packer.sv
`timescale 1ns/1ps
module group_packer
  import issue_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  q_entry_t                     head [WIDTH],
  input  logic [WIDTH-1:0]             head_vld,
  output lane_t                        lanes [WIDTH],
  output logic [$clog2(WIDTH+1)-1:0]   take_n
);
  localparam int unsigned NW = $clog2(WIDTH+1);
  localparam int unsigned UW = $clog2(WIDTH+3);

  always_comb begin
    logic [UW-1:0] used;
    logic          stop;
    used   = '0;
    stop   = 1'b0;
    take_n = '0;
    for (int j = 0; j < WIDTH; j++) lanes[j] = '0;
    // walk head entries in order; the first one that does not fit closes the group
    for (int k = 0; k < WIDTH; k++) begin
      if (!stop) begin
        if (!head_vld[k]) begin
          stop = 1'b1;
        end else if (head[k].split) begin
          if ((used + UW'(2)) <= UW'(WIDTH)) begin
            for (int j = 0; j < WIDTH; j++) begin
              if (UW'(j) == used) begin
                lanes[j].vld  = 1'b1;
                lanes[j].half = 1'b0;
                lanes[j].tag  = head[k].tag;
              end
              if (UW'(j) == (used + UW'(1))) begin
                lanes[j].vld  = 1'b1;
                lanes[j].half = 1'b1;
                lanes[j].tag  = head[k].tag;
              end
            end
            used   = used + UW'(2);
            take_n = take_n + NW'(1);
          end else begin
            stop = 1'b1;
          end
        end else begin
          if ((used + UW'(1)) <= UW'(WIDTH)) begin
            for (int j = 0; j < WIDTH; j++) begin
              if (UW'(j) == used) begin
                lanes[j].vld  = 1'b1;
                lanes[j].half = 1'b0;
                lanes[j].tag  = head[k].tag;
              end
            end
            used   = used + UW'(1);
            take_n = take_n + NW'(1);
          end else begin
            stop = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/perf_counters.sv
`timescale 1ns/1ps
module perf_counters #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WIDTH-1:0]  lane_vld,
  output logic [CNT_W-1:0]  cycles,
  output logic [CNT_W-1:0]  uops
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycles <= '0;
      uops   <= '0;
    end else if (fire) begin
      cycles <= cycles + CNT_W'(1);
      uops   <= uops + CNT_W'($countones(lane_vld));
    end
  end

  // counters move only on an issue handshake
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(cycles) && $stable(uops)));

  // an issuing cycle never adds more micro-ops than lanes
  assert_uop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((uops - $past(uops)) <= CNT_W'(WIDTH)) && ((uops - $past(uops)) != '0));
endmodule

// File: rtl/issue_grouper.sv
`timescale 1ns/1ps
module issue_grouper
  import issue_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [$clog2(WIDTH+1)-1:0]  in_count,
  input  logic [WIDTH-1:0]            in_split,
  input  logic [WIDTH*TAG_W-1:0]      in_tag,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WIDTH-1:0]            out_lane_vld,
  output logic [WIDTH-1:0]            out_lane_half,
  output logic [WIDTH*TAG_W-1:0]      out_lane_tag,
  output logic [CNT_W-1:0]            perf_cycles,
  output logic [CNT_W-1:0]            perf_uops
);
  localparam int unsigned NW = $clog2(WIDTH+1);

  q_entry_t           in_ent   [WIDTH];
  q_entry_t           head     [WIDTH];
  logic [WIDTH-1:0]   head_vld;
  lane_t              nxt      [WIDTH];
  lane_t              cur_q    [WIDTH];
  logic [NW-1:0]      take_n;
  logic [NW-1:0]      push_n;
  logic [NW-1:0]      pop_n;
  logic               space_ok;
  logic               load;
  logic               fire;

  for (genvar g = 0; g < WIDTH; g++) begin : g_unpack
    assign in_ent[g].split     = in_split[g];
    assign in_ent[g].tag       = in_tag[g*TAG_W +: TAG_W];
    assign out_lane_vld[g]     = cur_q[g].vld;
    assign out_lane_half[g]    = cur_q[g].half;
    assign out_lane_tag[g*TAG_W +: TAG_W] = cur_q[g].tag;
  end

  assign in_ready  = space_ok;
  assign push_n    = (in_valid && space_ok) ? in_count : '0;
  assign out_valid = |out_lane_vld;
  assign load      = !out_valid || out_ready;
  assign pop_n     = load ? take_n : '0;
  assign fire      = out_valid && out_ready;

  uop_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (push_n),
    .push_ent (in_ent),
    .pop_n    (pop_n),
    .head     (head),
    .head_vld (head_vld),
    .space_ok (space_ok)
  );

  group_packer #(.WIDTH(WIDTH)) u_pack (
    .head     (head),
    .head_vld (head_vld),
    .lanes    (nxt),
    .take_n   (take_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WIDTH; k++) cur_q[k] <= '0;
    end else if (load) begin
      for (int k = 0; k < WIDTH; k++) cur_q[k] <= nxt[k];
    end
  end

  perf_counters #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_perf (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .lane_vld (out_lane_vld),
    .cycles   (perf_cycles),
    .uops     (perf_uops)
  );

  // lanes fill from lane 0 with no gaps
  assert_packed_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_lane_vld & WIDTH'(out_lane_vld + WIDTH'(1))) == '0));

  // a stalled group stays put
  assert_hold_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lane_vld)
      && $stable(out_lane_half) && $stable(out_lane_tag)));

  // lane 0 can never carry a second half
  assert_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_lane_half[0]);

  // a second half always sits right above its first half, in the same group
  for (genvar g = 1; g < WIDTH; g++) begin : g_pair_chk
    assert_pair_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q[g].vld && cur_q[g].half) |->
        (cur_q[g-1].vld && !cur_q[g-1].half && (cur_q[g-1].tag == cur_q[g].tag)));
  end
endmodule

// File: tb/test_issue_grouper.sv
`timescale 1ns/1ps
module test_issue_grouper;
  localparam int TW = issue_pkg::TAG_W;
  localparam int NROW = 5;
  // per row: fused flags of eight entries (entry k on bit k)
  localparam logic [7:0]  ROW_SPLIT [NROW] = '{8'h00, 8'hFF, 8'h55, 8'h06, 8'h08};
  // per row: expected group sizes, group g on bits 3g+2:3g, 0 = no group
  localparam logic [11:0] ROW_SIZE  [NROW] = '{12'o0044, 12'o4444, 12'o3333, 12'o0343, 12'o0243};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [2:0]      in_count = 3'd4;
  logic [3:0]      in_split = '0;
  logic [4*TW-1:0] in_tag = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [3:0]      out_lane_vld;
  logic [3:0]      out_lane_half;
  logic [4*TW-1:0] out_lane_tag;
  logic [31:0]     perf_cycles;
  logic [31:0]     perf_uops;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  longint exp_cyc = 0;
  longint exp_uops = 0;

  always #10 clk = ~clk; // 20 ns period

  issue_grouper i_issue_grouper (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_count(in_count),
    .in_split(in_split), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_vld(out_lane_vld), .out_lane_half(out_lane_half), .out_lane_tag(out_lane_tag),
    .perf_cycles(perf_cycles), .perf_uops(perf_uops)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_batch(input logic [3:0] flags, input int base);
    in_valid = 1'b1;
    in_count = 3'd4;
    in_split = flags;
    for (int k = 0; k < 4; k++) in_tag[k*TW +: TW] = TW'(base + k);
  endtask

  task automatic run_stream(input logic [3:0] flags, input int per_cyc, input string req);
    longint c0 = 0, u0 = 0;
    out_ready = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (c == 10) begin c0 = perf_cycles; u0 = perf_uops; end
      if (c == 50) begin
        chk(perf_cycles - c0 == 40, req, "issuing cycles in window", perf_cycles - c0, 40);
        chk(perf_uops - u0 == 40*per_cyc, req, "uops in window", perf_uops - u0, 40*per_cyc);
      end
      set_batch(flags, c*4);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0, req, "drained after stream", out_valid, 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(perf_cycles == 0, "R9", "perf_cycles after reset", perf_cycles, 0);
    chk(perf_uops == 0, "R9", "perf_uops after reset", perf_uops, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    // table-driven group formation
    for (int r = 0; r < NROW; r++) begin
      logic [TW-1:0] et [16];
      logic          eh [16];
      int            nl;
      int            pos;
      logic [3:0]    hv;
      logic [4*TW-1:0] ht;
      nl = 0;
      for (int k = 0; k < 8; k++) begin
        et[nl] = TW'(r*8 + k); eh[nl] = 1'b0; nl++;
        if (ROW_SPLIT[r][k]) begin et[nl] = TW'(r*8 + k); eh[nl] = 1'b1; nl++; end
      end
      out_ready = 1'b0;
      set_batch(ROW_SPLIT[r][3:0], r*8);
      @(negedge clk);
      set_batch(ROW_SPLIT[r][7:4], r*8 + 4);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R6: stalled group holds
      hv = out_lane_vld; ht = out_lane_tag;
      @(negedge clk);
      chk(out_valid && out_lane_vld == hv, "R6", "held lane mask", out_lane_vld, hv);
      chk(out_lane_tag == ht, "R6", "held lane tags", out_lane_tag, ht);
      chk(perf_uops == exp_uops, "R6", "counter frozen while stalled", perf_uops, exp_uops);
      pos = 0;
      for (int g = 0; g < 4; g++) begin
        int sz;
        sz = int'(ROW_SIZE[r][g*3 +: 3]);
        if (sz != 0) begin
          chk(out_lane_vld == 4'((1 << sz) - 1), "R3 R5", "group lane mask",
              out_lane_vld, (1 << sz) - 1);
          for (int l = 0; l < sz; l++) begin
            chk(out_lane_tag[l*TW +: TW] == et[pos+l], "R4", "lane tag order",
                out_lane_tag[l*TW +: TW], et[pos+l]);
            chk(out_lane_half[l] == eh[pos+l], "R2", "lane half flag",
                out_lane_half[l], eh[pos+l]);
          end
          pos += sz;
          exp_cyc++;
          exp_uops += sz;
          out_ready = 1'b1;
          @(negedge clk);
        end
      end
      chk(out_valid == 1'b0, "R3", "no leftover group", out_valid, 0);
      chk(perf_cycles == exp_cyc, "R8", "perf_cycles total", perf_cycles, exp_cyc);
      chk(perf_uops == exp_uops, "R8", "perf_uops total", perf_uops, exp_uops);
      out_ready = 1'b0;
    end

    // throughput streams
    run_stream(4'b0000, 4, "R1");
    run_stream(4'b0101, 3, "R7");
    run_stream(4'b1111, 4, "R7");

    // R10: queue full refuses batches
    begin
      longint u0;
      out_ready = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (c == 4) chk(in_ready == 1'b0, "R10", "in_ready with queue full", in_ready, 0);
        set_batch(4'b1111, 100 + c*4);
      end
      @(negedge clk);
      in_valid = 1'b0;
      u0 = perf_uops;
      out_ready = 1'b1;
      repeat (20) @(negedge clk);
      chk(perf_uops - u0 == 32, "R10", "uops from accepted batches only", perf_uops - u0, 32);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule